// File: doc/BRIEF.md
# Central Stop Arbiter with Peer Notify

This block is the root error concentrator for one half of a system interconnect. Expander-level concentrators raise stop requests on a per-expander request bus, and local crossbar chips raise them on a separate crossbar stop bus. A second arbiter serving the other half of the interconnect is linked to this one by notify lines. Each side forwards the stop it has taken, so both halves declare the same stop.

Once a stop is taken, the arbiter runs a fixed three-phase sequence. First it centralises the request and notifies the peer. Next it broadcasts a one-cycle demand message to every crossbar chip and every expander concentrator. The message carries the stop type (domain stop or reset stop), the expander in error and the affected slot mask. Last, it waits for every recipient to acknowledge and then raises an interrupt to the system controller. The interrupt is held until the controller clears it.

The origin of the first request is kept in a readable register for the controller, together with the accumulated set of expanders in error. A flag shows that a request arrived after the broadcast, and another flag shows that the acknowledgement window ran out.

Top module: `stop_hub`

## Requirements
- R1: After reset, irq, dmd_valid, pout_valid, late_flag and tmo_flag are 0, accum_exp is all zero and origin_src is 0 (none).
- R2: A request seen while idle is captured as the first request. Priority is lowest-numbered expander, then lowest-numbered crossbar chip, then the peer. origin_src encodes the source (1 expander, 2 crossbar, 3 peer) and origin_idx gives its index (0 for the peer).
- R3: One cycle after the capture, pout_valid pulses for exactly one cycle with the captured kind, expander and slot mask. The pulse is omitted when the first request came from the peer.
- R4: Two cycles after the capture, dmd_valid pulses for exactly one cycle carrying the stop type (0 domain stop, 1 reset stop), the expander index and the slot mask. An expander request supplies its own slot mask, a crossbar request gives 2'b11 for its named expander, and a peer request supplies its own slot mask.
- R5: Acknowledge bits on rcv_ack are gathered from the cycle after the demand pulse onward, and bits seen during the demand cycle are not counted. irq rises in the cycle after every recipient bit has been seen, and tmo_flag stays 0.
- R6: If not every acknowledge bit has been seen within ACK_TMO cycles after the demand, irq rises anyway and tmo_flag is 1.
- R7: irq stays high until irq_clr is asserted while irq is high. One cycle after that, irq is 0 and origin, accumulation, late and timeout state are cleared. irq_clr at any other time has no effect.
- R8: accum_exp gathers, as a bit per expander index, every expander named by any request from the capture until the clear. origin_src and origin_idx do not change after the capture.
- R9: A request arriving while waiting for acknowledgements or while irq is high sets late_flag and produces no further demand pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exp_req | input | NEXP | Stop request, one bit per expander concentrator |
| exp_kind | input | NEXP | Requested stop type per expander (1 reset stop) |
| exp_slot | input | 2*NEXP | Slot mask per expander, 2 bits each |
| xb_req | input | NXB | Stop request, one bit per crossbar chip |
| xb_kind | input | NXB | Requested stop type per crossbar chip |
| xb_port | input | NXB*EW | Expander index named by each crossbar chip |
| pin_valid | input | 1 | Stop notification from the peer arbiter |
| pin_kind | input | 1 | Peer stop type |
| pin_exp | input | EW | Peer expander index |
| pin_slot | input | 2 | Peer slot mask |
| pout_valid | output | 1 | Stop notification to the peer arbiter |
| pout_kind | output | 1 | Notified stop type |
| pout_exp | output | EW | Notified expander index |
| pout_slot | output | 2 | Notified slot mask |
| dmd_valid | output | 1 | Stop demand broadcast pulse |
| dmd_kind | output | 1 | Demand stop type |
| dmd_exp | output | EW | Demand expander in error |
| dmd_slot | output | 2 | Demand slot mask |
| rcv_ack | input | NRCV | Demand processed, one bit per recipient |
| irq | output | 1 | Interrupt to the system controller |
| irq_clr | input | 1 | Controller clear of the interrupt |
| origin_src | output | 2 | Source class of the first request |
| origin_idx | output | IW | Index of the first requester |
| accum_exp | output | NEXP | Accumulated expanders in error |
| late_flag | output | 1 | Request seen after the broadcast |
| tmo_flag | output | 1 | Acknowledgement window ran out |

## Verification
A wrong sequence state in this block shows up at the ports within one or two cycles. A missing or doubled peer pulse appears the cycle after capture, a misplaced demand pulse appears two cycles after it, and an irq appears too early, too late or is dropped. A corrupted acknowledge record or window counter can stay hidden until the episode ends. It then shows as a wrong tmo_flag, or as an irq that arrives before the last bit or never arrives. Wrong priority or capture shows immediately in origin_src, origin_idx and the demand fields, and a wrong accumulation shows in accum_exp on the cycle after the offending request.

// File: rtl/stop_hub_pkg.sv
package stop_hub_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_COLLECT = 3'd1,
    PH_BCAST   = 3'd2,
    PH_WAIT    = 3'd3,
    PH_IRQ     = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXP  = 2'd1,
    SRC_XBAR = 2'd2,
    SRC_PEER = 2'd3
  } src_e;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Window counter step that never wraps.
  function automatic int unsigned step_sat(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

endpackage

// File: rtl/stop_req_merge.sv
module stop_req_merge
  import stop_hub_pkg::*;
#(
  parameter int NEXP = 4,
  parameter int NXB  = 4,
  parameter int EW   = 2,
  parameter int IW   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXP-1:0]   exp_req,
  input  logic [NEXP-1:0]   exp_kind,
  input  logic [2*NEXP-1:0] exp_slot,
  input  logic [NXB-1:0]    xb_req,
  input  logic [NXB-1:0]    xb_kind,
  input  logic [NXB*EW-1:0] xb_port,
  input  logic              pin_valid,
  input  logic              pin_kind,
  input  logic [EW-1:0]     pin_exp,
  input  logic [1:0]        pin_slot,
  output logic              any_req,
  output src_e              sel_src,
  output logic [IW-1:0]     sel_idx,
  output logic              sel_kind,
  output logic [EW-1:0]     sel_exp,
  output logic [1:0]        sel_slot,
  output logic [NEXP-1:0]   hit_mask
);

  int unsigned e_first;
  int unsigned x_first;
  logic [EW-1:0] x_port_sel;

  always_comb begin
    e_first    = lowest_set(32'(exp_req));
    x_first    = lowest_set(32'(xb_req));
    x_port_sel = xb_port[x_first*EW +: EW];
  end

  // Expanders named by any request this cycle.
  always_comb begin
    hit_mask = '0;
    for (int i = 0; i < NEXP; i++) begin
      if (exp_req[i]) hit_mask[i] = 1'b1;
    end
    for (int j = 0; j < NXB; j++) begin
      if (xb_req[j] && (int'(xb_port[j*EW +: EW]) < NEXP))
        hit_mask[xb_port[j*EW +: EW]] = 1'b1;
    end
    if (pin_valid && (int'(pin_exp) < NEXP)) hit_mask[pin_exp] = 1'b1;
  end

  // Fixed priority: expanders, then crossbar chips, then the peer.
  always_comb begin
    any_req  = (|exp_req) | (|xb_req) | pin_valid;
    sel_src  = SRC_NONE;
    sel_idx  = '0;
    sel_kind = 1'b0;
    sel_exp  = '0;
    sel_slot = 2'b00;
    if (|exp_req) begin
      sel_src  = SRC_EXP;
      sel_idx  = IW'(e_first);
      sel_kind = exp_kind[e_first];
      sel_exp  = EW'(e_first);
      sel_slot = exp_slot[e_first*2 +: 2];
    end else if (|xb_req) begin
      sel_src  = SRC_XBAR;
      sel_idx  = IW'(x_first);
      sel_kind = xb_kind[x_first];
      sel_exp  = x_port_sel;
      sel_slot = 2'b11;
    end else if (pin_valid) begin
      sel_src  = SRC_PEER;
      sel_kind = pin_kind;
      sel_exp  = pin_exp;
      sel_slot = pin_slot;
    end
  end

  assert_exp_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|exp_req) |-> (sel_src == SRC_EXP) && exp_req[sel_exp]);
  assert_peer_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_src == SRC_PEER) |-> pin_valid && !(|xb_req) && !(|exp_req));

endmodule

// File: rtl/stop_ack_track.sv
module stop_ack_track
  import stop_hub_pkg::*;
#(
  parameter int NRCV = 8,
  parameter int TMO  = 256,
  localparam int CW  = $clog2(TMO + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            active,
  input  logic [NRCV-1:0] ack,
  output logic            all_done,
  output logic            tmo_hit
);

  logic [NRCV-1:0] seen_q;
  logic [CW-1:0]   cnt_q;
  logic [NRCV-1:0] seen_now;

  assign seen_now = seen_q | ack;
  assign all_done = active && (&seen_now);
  assign tmo_hit  = active && !(&seen_now) && (cnt_q == CW'(TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      cnt_q  <= '0;
    end else if (arm) begin
      seen_q <= '0;
      cnt_q  <= '0;
    end else if (active) begin
      seen_q <= seen_now;
      if (!all_done) cnt_q <= CW'(step_sat(int'(cnt_q), TMO));
    end
  end

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < CW'(TMO)));
  assert_arm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (seen_q == '0) && (cnt_q == '0));

endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import stop_hub_pkg::*;
#(
  parameter int NEXP = 4,
  parameter int EW   = 2,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_req,
  input  src_e            sel_src,
  input  logic [IW-1:0]   sel_idx,
  input  logic            sel_kind,
  input  logic [EW-1:0]   sel_exp,
  input  logic [1:0]      sel_slot,
  input  logic [NEXP-1:0] hit_mask,
  input  logic            all_done,
  input  logic            tmo_hit,
  input  logic            irq_clr,
  output phase_e          phase,
  output src_e            cap_src,
  output logic [IW-1:0]   cap_idx,
  output logic            cap_kind,
  output logic [EW-1:0]   cap_exp,
  output logic [1:0]      cap_slot,
  output logic [NEXP-1:0] accum,
  output logic            late,
  output logic            tmo
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cap_src  <= SRC_NONE;
      cap_idx  <= '0;
      cap_kind <= 1'b0;
      cap_exp  <= '0;
      cap_slot <= 2'b00;
      accum    <= '0;
      late     <= 1'b0;
      tmo      <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (any_req) begin
            cap_src  <= sel_src;
            cap_idx  <= sel_idx;
            cap_kind <= sel_kind;
            cap_exp  <= sel_exp;
            cap_slot <= sel_slot;
            accum    <= hit_mask;
            phase    <= PH_COLLECT;
          end
        end
        PH_COLLECT: begin
          accum <= accum | hit_mask;
          phase <= PH_BCAST;
        end
        PH_BCAST: begin
          accum <= accum | hit_mask;
          phase <= PH_WAIT;
        end
        PH_WAIT: begin
          accum <= accum | hit_mask;
          if (any_req) late <= 1'b1;
          if (all_done) begin
            phase <= PH_IRQ;
          end else if (tmo_hit) begin
            phase <= PH_IRQ;
            tmo   <= 1'b1;
          end
        end
        PH_IRQ: begin
          if (irq_clr) begin
            phase    <= PH_IDLE;
            cap_src  <= SRC_NONE;
            cap_idx  <= '0;
            cap_kind <= 1'b0;
            cap_exp  <= '0;
            cap_slot <= 2'b00;
            accum    <= '0;
            late     <= 1'b0;
            tmo      <= 1'b0;
          end else begin
            accum <= accum | hit_mask;
            if (any_req) late <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_origin_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) && ($past(phase) != PH_IDLE) |->
      $stable(cap_src) && $stable(cap_idx));
  assert_accum_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) && ($past(phase) != PH_IDLE) |->
      ((accum & $past(accum)) == $past(accum)));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !late && !tmo && (accum == '0));

endmodule

// File: rtl/stop_hub.sv
module stop_hub
  import stop_hub_pkg::*;
#(
  parameter int NEXP    = 4,
  parameter int NXB     = 4,
  parameter int ACK_TMO = 256,
  localparam int EW     = (NEXP > 1) ? $clog2(NEXP) : 1,
  localparam int MAXN   = (NEXP > NXB) ? NEXP : NXB,
  localparam int IW     = (MAXN > 1) ? $clog2(MAXN) : 1,
  localparam int NRCV   = NEXP + NXB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXP-1:0]   exp_req,
  input  logic [NEXP-1:0]   exp_kind,
  input  logic [2*NEXP-1:0] exp_slot,
  input  logic [NXB-1:0]    xb_req,
  input  logic [NXB-1:0]    xb_kind,
  input  logic [NXB*EW-1:0] xb_port,
  input  logic              pin_valid,
  input  logic              pin_kind,
  input  logic [EW-1:0]     pin_exp,
  input  logic [1:0]        pin_slot,
  output logic              pout_valid,
  output logic              pout_kind,
  output logic [EW-1:0]     pout_exp,
  output logic [1:0]        pout_slot,
  output logic              dmd_valid,
  output logic              dmd_kind,
  output logic [EW-1:0]     dmd_exp,
  output logic [1:0]        dmd_slot,
  input  logic [NRCV-1:0]   rcv_ack,
  output logic              irq,
  input  logic              irq_clr,
  output logic [1:0]        origin_src,
  output logic [IW-1:0]     origin_idx,
  output logic [NEXP-1:0]   accum_exp,
  output logic              late_flag,
  output logic              tmo_flag
);

  // Named internal events
  logic            any_req;
  src_e            sel_src;
  logic [IW-1:0]   sel_idx;
  logic            sel_kind;
  logic [EW-1:0]   sel_exp;
  logic [1:0]      sel_slot;
  logic [NEXP-1:0] hit_mask;
  logic            all_done;
  logic            tmo_hit;
  phase_e          phase;
  src_e            cap_src;
  logic            ack_arm;
  logic            ack_active;

  stop_req_merge #(.NEXP(NEXP), .NXB(NXB), .EW(EW), .IW(IW)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .exp_req(exp_req), .exp_kind(exp_kind), .exp_slot(exp_slot),
    .xb_req(xb_req), .xb_kind(xb_kind), .xb_port(xb_port),
    .pin_valid(pin_valid), .pin_kind(pin_kind), .pin_exp(pin_exp), .pin_slot(pin_slot),
    .any_req(any_req), .sel_src(sel_src), .sel_idx(sel_idx), .sel_kind(sel_kind),
    .sel_exp(sel_exp), .sel_slot(sel_slot), .hit_mask(hit_mask)
  );

  stop_seq #(.NEXP(NEXP), .EW(EW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .any_req(any_req), .sel_src(sel_src), .sel_idx(sel_idx), .sel_kind(sel_kind),
    .sel_exp(sel_exp), .sel_slot(sel_slot), .hit_mask(hit_mask),
    .all_done(all_done), .tmo_hit(tmo_hit), .irq_clr(irq_clr),
    .phase(phase), .cap_src(cap_src), .cap_idx(origin_idx), .cap_kind(dmd_kind),
    .cap_exp(dmd_exp), .cap_slot(dmd_slot), .accum(accum_exp),
    .late(late_flag), .tmo(tmo_flag)
  );

  assign ack_arm    = (phase == PH_BCAST);
  assign ack_active = (phase == PH_WAIT);

  stop_ack_track #(.NRCV(NRCV), .TMO(ACK_TMO)) u_ack (
    .clk(clk), .rst_n(rst_n), .arm(ack_arm), .active(ack_active),
    .ack(rcv_ack), .all_done(all_done), .tmo_hit(tmo_hit)
  );

  assign origin_src = cap_src;
  assign pout_valid = (phase == PH_COLLECT) && (cap_src != SRC_PEER);
  assign pout_kind  = dmd_kind;
  assign pout_exp   = dmd_exp;
  assign pout_slot  = dmd_slot;
  assign dmd_valid  = (phase == PH_BCAST);
  assign irq        = (phase == PH_IRQ);

  assert_peer_no_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pout_valid |-> (origin_src != 2'd3) && (origin_src != 2'd0));
  assert_peer_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pout_valid |=> !pout_valid);
  assert_demand_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_valid |=> !dmd_valid && !irq);
  assert_demand_before_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_valid |-> !late_flag);
  assert_tmo_implies_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> irq);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && irq_clr |=> !irq && !tmo_flag && (accum_exp == '0));
  assert_irq_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> tmo_flag || $past(all_done));

endmodule

// File: tb/sim_stop_hub.sv
module sim_stop_hub;
  localparam int CLK_PER = 10;
  localparam int NEXP = 4;
  localparam int NXB  = 4;
  localparam int TMO  = 12;
  localparam int EW   = 2;
  localparam int IW   = 2;
  localparam int NRCV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic [NEXP-1:0]   exp_req = '0, exp_kind = '0;
  logic [2*NEXP-1:0] exp_slot = '0;
  logic [NXB-1:0]    xb_req = '0, xb_kind = '0;
  logic [NXB*EW-1:0] xb_port = '0;
  logic pin_valid = 1'b0, pin_kind = 1'b0;
  logic [EW-1:0] pin_exp = '0;
  logic [1:0] pin_slot = '0;
  logic [NRCV-1:0] rcv_ack = '0;
  logic irq_clr = 1'b0;
  logic pout_valid, pout_kind, dmd_valid, dmd_kind, irq, late_flag, tmo_flag;
  logic [EW-1:0] pout_exp, dmd_exp;
  logic [1:0] pout_slot, dmd_slot, origin_src;
  logic [IW-1:0] origin_idx;
  logic [NEXP-1:0] accum_exp;

  stop_hub #(.NEXP(NEXP), .NXB(NXB), .ACK_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .exp_req(exp_req), .exp_kind(exp_kind), .exp_slot(exp_slot),
    .xb_req(xb_req), .xb_kind(xb_kind), .xb_port(xb_port),
    .pin_valid(pin_valid), .pin_kind(pin_kind), .pin_exp(pin_exp), .pin_slot(pin_slot),
    .pout_valid(pout_valid), .pout_kind(pout_kind), .pout_exp(pout_exp), .pout_slot(pout_slot),
    .dmd_valid(dmd_valid), .dmd_kind(dmd_kind), .dmd_exp(dmd_exp), .dmd_slot(dmd_slot),
    .rcv_ack(rcv_ack), .irq(irq), .irq_clr(irq_clr),
    .origin_src(origin_src), .origin_idx(origin_idx), .accum_exp(accum_exp),
    .late_flag(late_flag), .tmo_flag(tmo_flag)
  );

  int checks = 0;
  int fails = 0;
  int dmd_seen = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: 0 idle, 1 notify, 2 demand, 3 awaiting acks, 4 interrupt
  int m_ph = 0, m_src = 0, m_idx = 0, m_exp = 0, m_slot = 0, m_cnt = 0;
  bit m_kind = 0, m_late = 0, m_tmo = 0;
  bit [NEXP-1:0] m_acc = '0;
  bit [NRCV-1:0] m_ack = '0;

  task automatic model_clear();
    m_src = 0; m_idx = 0; m_exp = 0; m_slot = 0; m_kind = 0;
    m_acc = '0; m_late = 0; m_tmo = 0;
  endtask

  task automatic model_step();
    bit anyr; bit [NEXP-1:0] hits;
    int fs, fi, fe, fsl; bit fk;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ack = '0; model_clear(); return;
    end
    anyr = 0; hits = '0; fs = 0; fi = 0; fe = 0; fsl = 0; fk = 0;
    // Later assignments win: list from lowest to highest priority.
    if (pin_valid) begin
      anyr = 1; hits[pin_exp] = 1; fs = 3; fi = 0; fe = pin_exp; fsl = pin_slot; fk = pin_kind;
    end
    for (int j = NXB-1; j >= 0; j--) if (xb_req[j]) begin
      anyr = 1; hits[xb_port[j*EW +: EW]] = 1; fs = 2; fi = j;
      fe = xb_port[j*EW +: EW]; fsl = 3; fk = xb_kind[j];
    end
    for (int i = NEXP-1; i >= 0; i--) if (exp_req[i]) begin
      anyr = 1; hits[i] = 1; fs = 1; fi = i; fe = i; fsl = exp_slot[2*i +: 2]; fk = exp_kind[i];
    end
    case (m_ph)
      0: if (anyr) begin
           m_ph = 1; m_src = fs; m_idx = fi; m_exp = fe; m_slot = fsl; m_kind = fk; m_acc = hits;
         end
      1: begin m_acc |= hits; m_ph = 2; end
      2: begin m_acc |= hits; m_ph = 3; m_ack = '0; m_cnt = 0; end
      3: begin
           m_acc |= hits;
           if (anyr) m_late = 1;
           m_ack |= rcv_ack;
           if (&m_ack) m_ph = 4;
           else if (m_cnt == TMO-1) begin m_ph = 4; m_tmo = 1; end
           else m_cnt++;
         end
      4: if (irq_clr) begin m_ph = 0; model_clear(); end
         else begin m_acc |= hits; if (anyr) m_late = 1; end
      default: m_ph = 0;
    endcase
  endtask

  always @(posedge clk) begin
    model_step();
    cyc++;
    if (cyc > 6000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Compare every output with the model on every falling edge.
  always @(negedge clk) begin
    if (dmd_valid === 1'b1) dmd_seen++;
    chk("R3 pout_valid", 32'(pout_valid), 32'(m_ph == 1 && m_src != 3));
    if (m_ph == 1 && m_src != 3) begin
      chk("R3 pout_kind", 32'(pout_kind), 32'(m_kind));
      chk("R3 pout_exp", 32'(pout_exp), 32'(m_exp));
      chk("R3 pout_slot", 32'(pout_slot), 32'(m_slot));
    end
    chk("R4 dmd_valid", 32'(dmd_valid), 32'(m_ph == 2));
    if (m_ph == 2) begin
      chk("R4 dmd_kind", 32'(dmd_kind), 32'(m_kind));
      chk("R4 dmd_exp", 32'(dmd_exp), 32'(m_exp));
      chk("R4 dmd_slot", 32'(dmd_slot), 32'(m_slot));
    end
    chk("R5 irq", 32'(irq), 32'(m_ph == 4));
    chk("R2 origin_src", 32'(origin_src), 32'(m_src));
    chk("R2 origin_idx", 32'(origin_idx), 32'(m_idx));
    chk("R8 accum_exp", 32'(accum_exp), 32'(m_acc));
    chk("R9 late_flag", 32'(late_flag), 32'(m_late));
    chk("R6 tmo_flag", 32'(tmo_flag), 32'(m_tmo));
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic drop_reqs();
    exp_req = '0; exp_kind = '0; exp_slot = '0;
    xb_req = '0; xb_kind = '0; xb_port = '0;
    pin_valid = 0; pin_kind = 0; pin_exp = '0; pin_slot = '0;
  endtask

  task automatic wait_dmd();
    for (int k = 0; k < 10; k++) begin
      if (dmd_valid === 1'b1) break;
      tick();
    end
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 40; k++) begin
      if (irq === 1'b1) break;
      tick();
    end
  endtask

  task automatic ack_all();
    rcv_ack = '1; tick(); rcv_ack = '0;
  endtask

  task automatic clear_irq();
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R7 irq after clear", 32'(irq), 0);
    chk("R7 origin after clear", 32'(origin_src), 0);
    tick();
  endtask

  initial begin
    int d0;
    repeat (3) tick();
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R1 dmd in reset", 32'(dmd_valid), 0);
    chk("R1 accum in reset", 32'(accum_exp), 0);
    chk("R1 origin in reset", 32'(origin_src), 0);
    rst_n = 1; tick();

    // Expander 2, domain stop, slot 01, all acks at once
    exp_req[2] = 1; exp_kind[2] = 0; exp_slot[5:4] = 2'b01; tick(); drop_reqs();
    wait_dmd();
    chk("R4 dmd slot exp2", 32'(dmd_slot), 1);
    tick(); ack_all();
    chk("R5 irq after acks", 32'(irq), 1);
    chk("R6 no timeout", 32'(tmo_flag), 0);
    chk("R2 origin exp", 32'(origin_src), 1);
    chk("R2 origin idx 2", 32'(origin_idx), 2);
    repeat (4) tick();
    chk("R7 irq holds", 32'(irq), 1);
    clear_irq();

    // Expander 3 and crossbar 1 (naming expander 0) together
    exp_req[3] = 1; exp_kind[3] = 1; exp_slot[7:6] = 2'b10;
    xb_req[1] = 1; xb_port[3:2] = 2'd0; tick(); drop_reqs();
    wait_dmd(); tick(); ack_all();
    chk("R2 expander beats crossbar", 32'(origin_idx), 3);
    chk("R8 accum both", 32'(accum_exp), 32'b1001);
    clear_irq();

    // Crossbar 2 alone, reset stop on expander 1
    xb_req[2] = 1; xb_kind[2] = 1; xb_port[5:4] = 2'd1; tick(); drop_reqs();
    wait_dmd();
    chk("R4 crossbar whole slot", 32'(dmd_slot), 3);
    chk("R4 reset stop kind", 32'(dmd_kind), 1);
    tick(); ack_all();
    chk("R2 origin crossbar", 32'(origin_src), 2);
    clear_irq();

    // Peer only: no echo on the notify lines
    pin_valid = 1; pin_kind = 1; pin_exp = 2'd2; pin_slot = 2'b01; tick(); drop_reqs();
    chk("R3 no echo to peer", 32'(pout_valid), 0);
    wait_dmd(); tick(); ack_all();
    chk("R2 origin peer", 32'(origin_src), 3);
    clear_irq();

    // Partial acks, stray clear during the wait: timeout
    exp_req[0] = 1; tick(); drop_reqs();
    wait_dmd(); tick();
    irq_clr = 1; rcv_ack = 8'h7F; tick(); irq_clr = 0;
    wait_irq(); rcv_ack = '0;
    chk("R6 timeout irq", 32'(irq), 1);
    chk("R6 timeout flag", 32'(tmo_flag), 1);
    clear_irq();

    // Late request during the wait, acks one bit per cycle
    d0 = dmd_seen;
    exp_req[0] = 1; tick(); drop_reqs();
    wait_dmd(); tick();
    exp_req[1] = 1; tick(); drop_reqs();
    for (int b = 0; b < NRCV; b++) begin
      rcv_ack = '0; rcv_ack[b] = 1'b1; tick();
    end
    rcv_ack = '0;
    chk("R9 late flag", 32'(late_flag), 1);
    chk("R8 late accum", 32'(accum_exp), 32'b0011);
    chk("R9 single demand", 32'(dmd_seen - d0), 1);
    chk("R5 spread acks irq", 32'(irq), 1);
    clear_irq();

    // Acks only during the demand cycle do not count
    exp_req[3] = 1; tick(); drop_reqs();
    wait_dmd(); rcv_ack = '1; tick(); rcv_ack = '0;
    wait_irq();
    chk("R5 early acks ignored", 32'(tmo_flag), 1);
    clear_irq();

    repeat (2) tick();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule